// File: doc/BRIEF.md
# HDLC Frame Transmitter

This block takes bytes from a host, holds them in a 128-entry byte queue, and sends them as HDLC frames on a one-bit serial line. A downstream framer supplies a bit request strobe. Each cycle in which that strobe is high, the framer takes the bit currently on `tx_bit_o`. While the channel is enabled, the block wraps every frame in flags and computes and appends the frame check sequence. It also inserts stuffing zeros, so that flag and abort patterns cannot appear inside a frame. When there is nothing to send, the line carries idle flags.

A frame starts for one of two reasons. Either a byte tagged as end of message is waiting, or the queue fill reaches an upper level chosen by a 2-bit setting. After it starts, the frame runs until its end-of-message byte has been sent. If the queue runs dry before that byte, the block sends an abort and raises a sticky underrun flag. The host can also force an abort at any time.

A ready status tells the host when the queue has room, measured against a lower level. A rising edge of ready sets a sticky flag. Each sticky flag can be routed to a shared interrupt line. A rising edge on a soft reset input restarts the transmitter and empties the queue.

Top module: `hdlc_tx_top`

## Requirements
- R1: The queue holds 128 bytes. `full_o` is 1 exactly when 128 bytes are stored, and `empty_o` is 1 exactly when none are stored. A write while full is dropped.
- R2: When the channel is enabled and a byte written with `wr_eom_i`=1 is queued, a frame is sent that contains every byte up to and including that byte, even a single-byte message.
- R3: Without a queued end-of-message byte, a frame starts only when the fill is at least 32*(`hi_thr_i`+1). Below that level no byte leaves the queue.
- R4: A frame on the line is, in order: a flag, the data bytes least significant bit first, two FCS bytes, and a closing flag. The flag is 0,1,1,1,1,1,1,0 in line order.
- R5: Inside data and FCS, a 0 is inserted after every five consecutive 1s, including a run that ends on the last FCS bit. Flags and aborts are never stuffed, so the line never carries more than seven 1s in a row while enabled.
- R6: The FCS is the CRC-16 with reflected polynomial 0x8408 (x^16+x^12+x^5+1), preset to 0xFFFF and taken over the data bits. It is sent inverted, low byte first and least significant bit first.
- R7: While enabled with no frame to send, the line carries back-to-back flags. While disabled, `tx_bit_o` is 1 and no bits are taken.
- R8: A one-cycle `abort_i` pulse empties the queue and replaces the rest of any frame with the abort pattern 0,1,1,1,1,1,1,1 (line order), followed by idle flags. No frame completes.
- R9: If the queue is empty when the next data byte is due and the last byte sent did not end the message, the abort pattern is sent and `udr_flag_o` is set. It stays set until `udr_clr_i`.
- R10: `ready_o` is 1 while the fill is below 32*(`lo_thr_i`+1). A 0-to-1 change of `ready_o` sets `rdy_flag_o`, which stays set until `rdy_clr_i`.
- R11: `irq_o` is 1 when (`rdy_flag_o` and `rdy_ie_i`) or (`udr_flag_o` and `udr_ie_i`).
- R12: A 0-to-1 edge on `soft_rst_i` empties the queue, clears both flags and sends the serializer back to idle flags. Holding `soft_rst_i` high has no further effect, and writes are accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| chan_en_i | input | 1 | Channel enable |
| soft_rst_i | input | 1 | Soft reset, acts on its rising edge |
| wr_i | input | 1 | Byte write strobe |
| wr_data_i | input | 8 | Byte to queue |
| wr_eom_i | input | 1 | Marks the written byte as end of message |
| abort_i | input | 1 | Abort command pulse |
| hi_thr_i | input | 2 | Upper start level select, level 32*(n+1) |
| lo_thr_i | input | 2 | Lower ready level select, level 32*(n+1) |
| rdy_ie_i | input | 1 | Ready interrupt enable |
| udr_ie_i | input | 1 | Underrun interrupt enable |
| rdy_clr_i | input | 1 | Clears the ready flag |
| udr_clr_i | input | 1 | Clears the underrun flag |
| bit_req_i | input | 1 | Line takes `tx_bit_o` this cycle |
| tx_bit_o | output | 1 | Serial line bit |
| full_o | output | 1 | Queue full |
| empty_o | output | 1 | Queue empty |
| ready_o | output | 1 | Fill below lower level |
| rdy_flag_o | output | 1 | Sticky ready-rise flag |
| udr_flag_o | output | 1 | Sticky underrun flag |
| irq_o | output | 1 | Interrupt |

## Verification
A wrong stuffing counter or bit counter shows up within one byte time. A stray six-ones run decodes as a flag, and a slipped bit breaks the frame's byte alignment. A receiver model in the bench decodes the line and compares each frame and its FCS against values it computes itself, so a corrupted CRC register is seen at the closing flag of the same frame. Errors in the end-of-message tracking or the start levels show up as frames that start too early, never start, or end in an abort. The bench catches these through the queue status and the abort count within a few hundred cycles.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;
  localparam logic [7:0]  FLAG_BYTE  = 8'h7E;
  localparam logic [7:0]  ABORT_BYTE = 8'hFE; // line order 0 then seven 1s
  localparam logic [15:0] CRC_INIT   = 16'hFFFF;
  localparam logic [15:0] CRC_POLY_R = 16'h8408;

  typedef enum logic [2:0] {
    ST_IDLE, ST_OPEN, ST_DATA, ST_FCS_LO, ST_FCS_HI, ST_CLOSE, ST_ABORT
  } tx_state_e;

  function automatic logic [15:0] crc_step(input logic [15:0] c, input logic b);
    return (c[0] ^ b) ? ((c >> 1) ^ CRC_POLY_R) : (c >> 1);
  endfunction
endpackage

// File: rtl/hdlc_tx_fifo.sv
module hdlc_tx_fifo #(
  parameter int DEPTH = 128,
  parameter int WIDTH = 9,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             push_i,
  input  logic [WIDTH-1:0] din_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] dout_o,
  output logic [CW-1:0]    count_o,
  output logic             full_o,
  output logic             empty_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [AW-1:0]    wp_q, rp_q;
  logic [CW-1:0]    cnt_q;
  logic             do_push, do_pop;

  function automatic logic [AW-1:0] adv(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign dout_o  = mem_q[rp_q];
  assign count_o = cnt_q;

  always_ff @(posedge clk_i) begin
    if (do_push && !clr_i) mem_q[wp_q] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q <= '0; rp_q <= '0; cnt_q <= '0;
    end else if (clr_i) begin
      wp_q <= '0; rp_q <= '0; cnt_q <= '0;
    end else begin
      if (do_push) wp_q <= adv(wp_q);
      if (do_pop)  rp_q <= adv(rp_q);
      cnt_q <= cnt_q + CW'(do_push) - CW'(do_pop);
    end
  end
endmodule

// File: rtl/hdlc_tx_stat.sv
module hdlc_tx_stat #(
  parameter int DEPTH = 128,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int STEP = DEPTH / 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          q_clr_i,
  input  logic          flag_clr_i,
  input  logic [CW-1:0] count_i,
  input  logic          push_eom_i,
  input  logic          pop_eom_i,
  input  logic [1:0]    hi_thr_i,
  input  logic [1:0]    lo_thr_i,
  input  logic          rdy_ie_i,
  input  logic          udr_ie_i,
  input  logic          rdy_clr_i,
  input  logic          udr_clr_i,
  input  logic          udr_set_i,
  output logic          start_o,
  output logic          ready_o,
  output logic          rdy_flag_o,
  output logic          udr_flag_o,
  output logic          irq_o
);
  logic [CW-1:0] eom_cnt_q, hi_lvl, lo_lvl;
  logic          rdy_prev_q;

  assign hi_lvl  = CW'(STEP * (int'(hi_thr_i) + 1));
  assign lo_lvl  = CW'(STEP * (int'(lo_thr_i) + 1));
  assign start_o = (eom_cnt_q != '0) || (count_i >= hi_lvl);
  assign ready_o = (count_i < lo_lvl);
  assign irq_o   = (rdy_flag_o && rdy_ie_i) || (udr_flag_o && udr_ie_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      eom_cnt_q  <= '0;
      rdy_prev_q <= 1'b1;
      rdy_flag_o <= 1'b0;
      udr_flag_o <= 1'b0;
    end else begin
      rdy_prev_q <= ready_o;
      if (q_clr_i) eom_cnt_q <= '0;
      else eom_cnt_q <= eom_cnt_q + CW'(push_eom_i) - CW'(pop_eom_i);
      if (flag_clr_i) begin
        rdy_flag_o <= 1'b0;
        udr_flag_o <= 1'b0;
      end else begin
        if (ready_o && !rdy_prev_q) rdy_flag_o <= 1'b1;
        else if (rdy_clr_i)         rdy_flag_o <= 1'b0;
        if (udr_set_i)              udr_flag_o <= 1'b1;
        else if (udr_clr_i)         udr_flag_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/hdlc_tx_ser.sv
module hdlc_tx_ser
  import hdlc_tx_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       en_i,
  input  logic       req_i,
  input  logic       abort_i,
  input  logic       start_i,
  input  logic       empty_i,
  input  logic [7:0] head_i,
  input  logic       head_eom_i,
  output logic       pop_o,
  output logic       udr_o,
  output logic       bit_o
);
  tx_state_e   st_q, nx_st;
  logic [7:0]  sh_q, nx_sh;
  logic [2:0]  bcnt_q, ones_q;
  logic [15:0] crc_q, crc_n;
  logic        eom_q, stuff_now, take, boundary, nx_pop, nx_udr, stuffed_seg;

  assign stuff_now   = (ones_q == 3'd5);
  assign take        = en_i && req_i && !abort_i && !clr_i;
  assign boundary    = take && !stuff_now && (bcnt_q == 3'd7);
  assign crc_n       = crc_step(crc_q, sh_q[0]);
  assign stuffed_seg = (st_q == ST_DATA) || (st_q == ST_FCS_LO) || (st_q == ST_FCS_HI);
  assign bit_o       = en_i ? (stuff_now ? 1'b0 : sh_q[0]) : 1'b1;
  assign pop_o       = boundary && nx_pop;
  assign udr_o       = boundary && nx_udr;

  always_comb begin
    nx_st  = ST_IDLE;
    nx_sh  = FLAG_BYTE;
    nx_pop = 1'b0;
    nx_udr = 1'b0;
    unique case (st_q)
      ST_OPEN, ST_DATA: begin
        if (st_q == ST_DATA && eom_q) begin
          nx_st = ST_FCS_LO;
          nx_sh = ~crc_n[7:0];
        end else if (empty_i) begin
          nx_st  = ST_ABORT;
          nx_sh  = ABORT_BYTE;
          nx_udr = 1'b1;
        end else begin
          nx_st  = ST_DATA;
          nx_sh  = head_i;
          nx_pop = 1'b1;
        end
      end
      ST_FCS_LO: begin
        nx_st = ST_FCS_HI;
        nx_sh = ~crc_q[15:8];
      end
      ST_FCS_HI: nx_st = ST_CLOSE;
      default:   nx_st = start_i ? ST_OPEN : ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE; sh_q <= FLAG_BYTE; bcnt_q <= '0; ones_q <= '0;
      crc_q <= CRC_INIT; eom_q <= 1'b0;
    end else if (clr_i || !en_i) begin
      st_q <= ST_IDLE; sh_q <= FLAG_BYTE; bcnt_q <= '0; ones_q <= '0;
      crc_q <= CRC_INIT; eom_q <= 1'b0;
    end else if (abort_i) begin
      st_q <= ST_ABORT; sh_q <= ABORT_BYTE; bcnt_q <= '0; ones_q <= '0;
    end else if (take) begin
      if (stuff_now) begin
        ones_q <= '0;
      end else begin
        ones_q <= (stuffed_seg && sh_q[0]) ? 3'(ones_q + 3'd1) : 3'd0;
        if (st_q == ST_DATA) crc_q <= crc_n;
        bcnt_q <= 3'(bcnt_q + 3'd1);
        if (bcnt_q == 3'd7) begin
          st_q <= nx_st;
          sh_q <= nx_sh;
          if (nx_pop) eom_q <= head_eom_i;
          if (nx_st == ST_ABORT) ones_q <= '0;
          if (nx_st == ST_OPEN) crc_q <= CRC_INIT;
        end else begin
          sh_q <= sh_q >> 1;
        end
      end
    end
  end
endmodule

// File: rtl/hdlc_tx_top.sv
module hdlc_tx_top #(
  parameter int DEPTH = 128,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       chan_en_i,
  input  logic       soft_rst_i,
  input  logic       wr_i,
  input  logic [7:0] wr_data_i,
  input  logic       wr_eom_i,
  input  logic       abort_i,
  input  logic [1:0] hi_thr_i,
  input  logic [1:0] lo_thr_i,
  input  logic       rdy_ie_i,
  input  logic       udr_ie_i,
  input  logic       rdy_clr_i,
  input  logic       udr_clr_i,
  input  logic       bit_req_i,
  output logic       tx_bit_o,
  output logic       full_o,
  output logic       empty_o,
  output logic       ready_o,
  output logic       rdy_flag_o,
  output logic       udr_flag_o,
  output logic       irq_o
);
  logic          srst_q, srst_pulse, q_clr, push, pop, udr, start;
  logic [8:0]    head;
  logic [CW-1:0] count;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) srst_q <= 1'b0;
    else         srst_q <= soft_rst_i;
  end

  assign srst_pulse = soft_rst_i && !srst_q;
  assign q_clr      = srst_pulse || abort_i;
  assign push       = wr_i && !full_o && !q_clr;

  hdlc_tx_fifo #(.DEPTH(DEPTH), .WIDTH(9)) u_fifo (
    .clk_i, .rst_ni, .clr_i(q_clr), .push_i(push), .din_i({wr_eom_i, wr_data_i}),
    .pop_i(pop), .dout_o(head), .count_o(count), .full_o, .empty_o
  );

  hdlc_tx_stat #(.DEPTH(DEPTH)) u_stat (
    .clk_i, .rst_ni, .q_clr_i(q_clr), .flag_clr_i(srst_pulse), .count_i(count),
    .push_eom_i(push && wr_eom_i), .pop_eom_i(pop && head[8]),
    .hi_thr_i, .lo_thr_i, .rdy_ie_i, .udr_ie_i, .rdy_clr_i, .udr_clr_i,
    .udr_set_i(udr), .start_o(start), .ready_o, .rdy_flag_o, .udr_flag_o, .irq_o
  );

  hdlc_tx_ser u_ser (
    .clk_i, .rst_ni, .clr_i(srst_pulse), .en_i(chan_en_i), .req_i(bit_req_i),
    .abort_i, .start_i(start), .empty_i(empty_o), .head_i(head[7:0]),
    .head_eom_i(head[8]), .pop_o(pop), .udr_o(udr), .bit_o(tx_bit_o)
  );
endmodule

// File: rtl/hdlc_tx_chk.sv
module hdlc_tx_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic chan_en_i,
  input logic soft_rst_i,
  input logic rdy_clr_i,
  input logic bit_req_i,
  input logic tx_bit_o,
  input logic full_o,
  input logic empty_o,
  input logic ready_o,
  input logic rdy_flag_o
);
  logic [3:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  run_q <= '0;
    else if (!chan_en_i)          run_q <= '0;
    else if (bit_req_i) begin
      if (!tx_bit_o)              run_q <= '0;
      else if (run_q != 4'd15)    run_q <= run_q + 4'd1;
    end
  end

  assert_full_empty_excl_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(full_o && empty_o));

  assert_ones_run_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q <= 4'd7);

  assert_rdy_rise_sets_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) && !soft_rst_i |=> rdy_flag_o);

  assert_rdy_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdy_flag_o && !rdy_clr_i && !soft_rst_i |=> rdy_flag_o);

  assert_soft_rst_clears_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(soft_rst_i) |=> empty_o);
endmodule

bind hdlc_tx_top hdlc_tx_chk u_chk (
  .clk_i, .rst_ni, .chan_en_i, .soft_rst_i, .rdy_clr_i, .bit_req_i,
  .tx_bit_o, .full_o, .empty_o, .ready_o, .rdy_flag_o
);

// File: tb/hdlc_tx_top_tb.sv
module hdlc_tx_top_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic chan_en = 0, soft_rst = 0, wr = 0, wr_eom = 0, abort_c = 0;
  logic [7:0] wr_data = '0;
  logic [1:0] hi_thr = '0, lo_thr = '0;
  logic rdy_ie = 0, udr_ie = 0, rdy_clr = 0, udr_clr = 0, bit_req = 1;
  logic tx_bit, full, empty, ready, rdy_flag, udr_flag, irq;

  int n_chk = 0, n_bad = 0, cyc = 0;
  // receiver model state
  int ones = 0, nbits = 0, frame_cnt = 0, abort_cnt = 0, flag_cnt = 0, last_len = 0, last_rem = 0;
  bit in_frame = 0;
  bit rxb [1024];
  logic [7:0] rx_frame [128];
  logic [7:0] tx_buf [64];

  always #10 clk = ~clk;

  hdlc_tx_top u_dut (
    .clk_i(clk), .rst_ni(rst_n), .chan_en_i(chan_en), .soft_rst_i(soft_rst),
    .wr_i(wr), .wr_data_i(wr_data), .wr_eom_i(wr_eom), .abort_i(abort_c),
    .hi_thr_i(hi_thr), .lo_thr_i(lo_thr), .rdy_ie_i(rdy_ie), .udr_ie_i(udr_ie),
    .rdy_clr_i(rdy_clr), .udr_clr_i(udr_clr), .bit_req_i(bit_req),
    .tx_bit_o(tx_bit), .full_o(full), .empty_o(empty), .ready_o(ready),
    .rdy_flag_o(rdy_flag), .udr_flag_o(udr_flag), .irq_o(irq)
  );

  task automatic push_bit(input bit b);
    if (nbits < 1024) rxb[nbits] = b;
    nbits++;
  endtask

  task automatic rx_bit(input bit b);
    if (b) begin
      ones++;
      if (ones == 7) begin abort_cnt++; in_frame = 0; nbits = 0; end
      else if (ones < 7 && in_frame) push_bit(1'b1);
    end else if (ones == 5) begin
      ones = 0;
    end else if (ones == 6) begin
      flag_cnt++;
      if (in_frame) begin
        nbits -= 7;
        if (nbits > 0) begin
          frame_cnt++;
          last_len = nbits / 8;
          last_rem = nbits % 8;
          for (int i = 0; i < last_len && i < 128; i++)
            for (int j = 0; j < 8; j++) rx_frame[i][j] = rxb[8*i+j];
        end
      end
      in_frame = 1; nbits = 0; ones = 0;
    end else begin
      ones = 0;
      if (in_frame) push_bit(1'b0);
    end
  endtask

  always @(negedge clk) if (rst_n && chan_en && bit_req) rx_bit(tx_bit);

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic check_eq(input string req, input string what, input int act, input int exp);
    check(act == exp, req, what, act, exp);
  endtask

  function automatic logic [15:0] fcs_of(input int n);
    logic [15:0] c = 16'hFFFF;
    for (int i = 0; i < n; i++)
      for (int j = 0; j < 8; j++)
        c = (c[0] ^ tx_buf[i][j]) ? ((c >> 1) ^ 16'h8408) : (c >> 1);
    return ~c;
  endfunction

  task automatic wr_byte(input logic [7:0] d, input logic eom);
    wr = 1; wr_data = d; wr_eom = eom;
    @(negedge clk);
    wr = 0; wr_eom = 0;
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse(ref logic s);
    s = 1; @(negedge clk); s = 0;
  endtask

  task automatic t_reset();
    check_eq("R1", "empty after reset", empty, 1);
    check_eq("R1", "full after reset", full, 0);
    check_eq("R10", "ready after reset", ready, 1);
    check_eq("R11", "irq after reset", irq, 0);
    check_eq("R9", "udr flag after reset", udr_flag, 0);
  endtask

  task automatic t_full();
    chan_en = 0;
    for (int i = 0; i < 127; i++) wr_byte(8'(i), 1'b0);
    check_eq("R1", "full at 127", full, 0);
    check_eq("R10", "ready at 127 lo=0", ready, 0);
    wr_byte(8'h55, 1'b0);
    check_eq("R1", "full at 128", full, 1);
    check_eq("R1", "not empty at 128", empty, 0);
    wr_byte(8'h66, 1'b0);
    check_eq("R1", "still full after extra write", full, 1);
    check_eq("R7", "line idle 1 while disabled", tx_bit, 1);
    soft_rst = 1; @(negedge clk);
    check_eq("R12", "empty after soft reset edge", empty, 1);
    check_eq("R12", "flags cleared by soft reset", rdy_flag, 0);
    wr_byte(8'h11, 1'b0); wr_byte(8'h22, 1'b0); wr_byte(8'h33, 1'b0);
    check_eq("R12", "held soft reset does not clear", empty, 0);
    soft_rst = 0; @(negedge clk);
    soft_rst = 1; @(negedge clk);
    soft_rst = 0;
    check_eq("R12", "second edge clears", empty, 1);
    wait_cyc(2);
    pulse(rdy_clr);
  endtask

  task automatic t_idle();
    int f0, fr0;
    chan_en = 1;
    f0 = flag_cnt; fr0 = frame_cnt;
    wait_cyc(90);
    check(flag_cnt - f0 >= 9, "R7", "idle flags seen", flag_cnt - f0, 9);
    check_eq("R7", "no frame while idle", frame_cnt - fr0, 0);
  endtask

  task automatic run_frame(input int n, input string req);
    int fr0, ab0, mism, t;
    logic [15:0] fcs;
    fr0 = frame_cnt; ab0 = abort_cnt;
    for (int i = 0; i < n; i++) wr_byte(tx_buf[i], i == n - 1);
    t = 0;
    while (frame_cnt == fr0 && t < 3000) begin @(negedge clk); t++; end
    check_eq(req, "frame received", frame_cnt - fr0, 1);
    check_eq("R4", "frame length", last_len, n + 2);
    check_eq("R4", "frame bit alignment", last_rem, 0);
    mism = 0;
    for (int i = 0; i < n; i++) if (rx_frame[i] !== tx_buf[i]) mism++;
    check_eq(req, "data byte mismatches", mism, 0);
    fcs = fcs_of(n);
    check_eq("R6", "fcs low", int'(rx_frame[n]), int'(fcs[7:0]));
    check_eq("R6", "fcs high", int'(rx_frame[n+1]), int'(fcs[15:8]));
    check_eq("R2", "queue drained", empty, 1);
    check_eq("R9", "no abort in good frame", abort_cnt - ab0, 0);
  endtask

  task automatic t_frames();
    tx_buf[0] = 8'h01; tx_buf[1] = 8'hFF; tx_buf[2] = 8'h7E;
    tx_buf[3] = 8'h3F; tx_buf[4] = 8'hF8; tx_buf[5] = 8'hA5;
    run_frame(6, "R5");
    tx_buf[0] = 8'h00;
    run_frame(1, "R2");
    for (int i = 0; i < 10; i++) tx_buf[i] = 8'hFF;
    run_frame(10, "R5");
    for (int i = 0; i < 33; i++) tx_buf[i] = 8'(i * 37 + 5);
    run_frame(33, "R4");
  endtask

  task automatic t_threshold();
    int fr0, ab0, t;
    hi_thr = 2'd0; lo_thr = 2'd0; udr_ie = 1; rdy_ie = 0;
    pulse(rdy_clr); pulse(udr_clr);
    fr0 = frame_cnt; ab0 = abort_cnt;
    for (int i = 0; i < 31; i++) wr_byte(8'(i + 1), 1'b0);
    wait_cyc(300);
    check_eq("R3", "no start below upper level", empty, 0);
    check_eq("R3", "no abort below upper level", abort_cnt - ab0, 0);
    check_eq("R11", "irq low before flags", irq, 0);
    for (int i = 31; i < 40; i++) wr_byte(8'(i + 1), 1'b0);
    check_eq("R10", "ready low above lower level", ready, 0);
    t = 0;
    while (abort_cnt == ab0 && t < 3000) begin @(negedge clk); t++; end
    check_eq("R9", "underrun abort sent", abort_cnt - ab0, 1);
    check_eq("R9", "no frame completed", frame_cnt - fr0, 0);
    check_eq("R9", "udr flag set", udr_flag, 1);
    check_eq("R3", "threshold frame drained queue", empty, 1);
    check_eq("R10", "ready rise flag set", rdy_flag, 1);
    check_eq("R11", "irq from udr", irq, 1);
    udr_ie = 0; @(negedge clk);
    check_eq("R11", "irq masked", irq, 0);
    rdy_ie = 1; @(negedge clk);
    check_eq("R11", "irq from rdy", irq, 1);
    pulse(rdy_clr);
    check_eq("R10", "rdy flag cleared", rdy_flag, 0);
    check_eq("R9", "udr flag still set", udr_flag, 1);
    pulse(udr_clr);
    check_eq("R9", "udr flag cleared", udr_flag, 0);
    rdy_ie = 0;
  endtask

  task automatic t_abort();
    int fr0, ab0, f0;
    fr0 = frame_cnt; ab0 = abort_cnt;
    for (int i = 0; i < 20; i++) wr_byte(8'(i * 3), i == 19);
    wait_cyc(60);
    pulse(abort_c);
    check_eq("R8", "queue emptied by abort", empty, 1);
    f0 = flag_cnt;
    wait_cyc(120);
    check_eq("R8", "abort pattern seen", abort_cnt - ab0, 1);
    check_eq("R8", "aborted frame not completed", frame_cnt - fr0, 0);
    check(flag_cnt - f0 >= 5, "R8", "idle flags after abort", flag_cnt - f0, 5);
  endtask

  task automatic t_soft_mid();
    int f0;
    for (int i = 0; i < 20; i++) wr_byte(8'(i + 9), i == 19);
    wait_cyc(60);
    soft_rst = 1; @(negedge clk); soft_rst = 0;
    check_eq("R12", "soft reset clears mid frame", empty, 1);
    wait_cyc(20);
    f0 = flag_cnt;
    wait_cyc(100);
    check(flag_cnt - f0 >= 8, "R12", "idle flags after soft reset", flag_cnt - f0, 8);
  endtask

  task automatic finish_up();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 150000);
      finish_up();
    end
  end

  initial begin
    wait_cyc(3);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_full();
    t_idle();
    t_frames();
    t_threshold();
    t_abort();
    t_soft_mid();
    finish_up();
  end
endmodule